// File: doc/BRIEF.md
# Region Write-Protection Checker

This block guards the external-data write path of a processor that reaches four memory regions, each through its own chip-enable. For every write, the processor supplies a strobe, the index of the target region and the byte offset inside that region. The block tests whether that offset falls inside a protected window at the bottom of the region. If it does, and the region has protection switched on, the write strobe is withheld from the memory and a sticky violation flag is raised. The flag can drive an interrupt request.

Protection is controlled by one 8-bit control register. It holds a protection enable for each region and a 3-bit size code that all four regions share. The code sets the window in 2 kB steps, from 2 kB up to 16 kB. The register also holds the violation flag. Read strobes and instruction-fetch strobes never reach the comparison and pass straight through.

Top module: `wrprot_gate`

## Requirements
- R1: After reset the control register reads 0x00: no region is protected and the violation flag is clear, so every write strobe passes.
- R2: Control bits 3..0 are the protection enables, with bit r belonging to region index r. An enable affects only writes whose region index equals r.
- R3: Control bits 6..4 hold a size code n that protects offsets strictly below (n+1)×2048. With code 0, offset 0x07FF is protected and 0x0800 is not. With code 7, offset 0x3FFF is protected and 0x4000 is not.
- R4: A write request to a protected offset of an enabled region leaves `wr_strb_o` low in that cycle.
- R5: Any write that is not blocked drives `wr_strb_o` equal to `wr_req_i` in the same cycle, with no register delay.
- R6: A blocked write sets control bit 7, the violation flag, at the next clock edge. `viol_irq_o` mirrors that bit.
- R7: The violation flag stays set until a configuration write carries 0 in bit 7. A configuration write carrying 1 in bit 7 never sets the flag or changes its value.
- R8: When a blocked write and a configuration write that clears the flag happen in the same cycle, the flag ends up set. In that same cycle, bits 6..0 still take the written values.
- R9: Read and fetch strobes leave the block equal to their inputs whatever the protection state. They never set the violation flag.
- R10: A configuration write updates bits 6..0 at the next clock edge. The new settings govern writes from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req_i | input | 1 | External-data write strobe from the processor |
| rd_req_i | input | 1 | External-data read strobe |
| fetch_req_i | input | 1 | Instruction-fetch strobe |
| rgn_sel_i | input | 2 | Index of the addressed chip-enable region |
| ofs_i | input | OFS_W | Byte offset inside the region |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register contents |
| wr_strb_o | output | 1 | Gated write strobe to memory |
| rd_strb_o | output | 1 | Read strobe to memory |
| fetch_strb_o | output | 1 | Fetch strobe to memory |
| viol_irq_o | output | 1 | Violation flag, usable as interrupt request |

## Verification
The hardest case to reach is a blocked write landing in the same cycle as a software clear of the flag. Reaching it needs protection already configured and a protected-offset write timed to that exact edge. The stimulus first programs a region, then issues that write together with a configuration write of 0 in bit 7. Window edges are covered by sweeping every size code and testing the offsets just below and exactly at each limit. A long random phase follows, with offsets biased toward the limits and occasional reconfiguration.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int WP_NUM_RGN = 4;
    localparam int WP_SEL_W   = $clog2(WP_NUM_RGN);
    localparam int WP_CODE_W  = 3;
    localparam int WP_CFG_W   = 8;

    // Bit layout of the control register
    typedef struct packed {
        logic                  viol;
        logic [WP_CODE_W-1:0]  code;
        logic [WP_NUM_RGN-1:0] en;
    } wp_ctrl_t;

    // Classification of an access seen by the gate
    typedef enum logic [1:0] {
        WP_IDLE    = 2'd0,
        WP_PASS    = 2'd1,
        WP_BLOCKED = 2'd2
    } wp_verdict_e;

    // Number of window steps covered by a size code
    function automatic logic [WP_CODE_W:0] wp_steps(input logic [WP_CODE_W-1:0] code);
        return {1'b0, code} + {{WP_CODE_W{1'b0}}, 1'b1};
    endfunction

    function automatic wp_ctrl_t wp_unpack(input logic [WP_CFG_W-1:0] raw);
        return wp_ctrl_t'(raw);
    endfunction

endpackage

// File: rtl/wp_ctrl_reg.sv
module wp_ctrl_reg
    import wp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [WP_CFG_W-1:0] cfg_wdata,
    input  logic                viol_set,
    output wp_ctrl_t            ctrl
);

    wp_ctrl_t wr_view;

    always_comb begin
        wr_view = wp_unpack(cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (cfg_we) begin
                ctrl.en   <= wr_view.en;
                ctrl.code <= wr_view.code;
            end
            // hardware set has priority over a software clear
            if (viol_set) begin
                ctrl.viol <= 1'b1;
            end else if (cfg_we && !wr_view.viol) begin
                ctrl.viol <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wp_window_cmp.sv
module wp_window_cmp
    import wp_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int STEP_LOG2 = 11
) (
    input  logic [WP_CODE_W-1:0] code,
    input  logic [OFS_W-1:0]     ofs,
    output logic                 in_window
);

    localparam int SPAN_W = STEP_LOG2 + WP_CODE_W + 1;
    localparam int LIM_W  = ((SPAN_W > OFS_W) ? SPAN_W : OFS_W) + 1;

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] ofs_ext;

    always_comb begin
        limit   = {{(LIM_W-WP_CODE_W-1){1'b0}}, wp_steps(code)} << STEP_LOG2;
        ofs_ext = {{(LIM_W-OFS_W){1'b0}}, ofs};
        in_window = (ofs_ext < limit);
    end

endmodule

// File: rtl/wp_region_sel.sv
module wp_region_sel
    import wp_pkg::*;
(
    input  logic [WP_NUM_RGN-1:0] en,
    input  logic [WP_SEL_W-1:0]   sel,
    output logic [WP_NUM_RGN-1:0] hit
);

    for (genvar r = 0; r < WP_NUM_RGN; r++) begin : g_rgn
        always_comb begin
            hit[r] = en[r] && (sel == WP_SEL_W'(r));
        end
    end

endmodule

// File: rtl/wp_strobe_gate.sv
module wp_strobe_gate
    import wp_pkg::*;
(
    input  logic        wr_req,
    input  logic        rd_req,
    input  logic        fetch_req,
    input  logic        guarded,
    output logic        wr_strb,
    output logic        rd_strb,
    output logic        fetch_strb,
    output wp_verdict_e verdict
);

    always_comb begin
        if (!wr_req) begin
            verdict = WP_IDLE;
        end else if (guarded) begin
            verdict = WP_BLOCKED;
        end else begin
            verdict = WP_PASS;
        end
        wr_strb    = (verdict == WP_PASS);
        rd_strb    = rd_req;
        fetch_strb = fetch_req;
    end

endmodule

// File: rtl/wrprot_gate.sv
module wrprot_gate
    import wp_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int STEP_LOG2 = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_req_i,
    input  logic                rd_req_i,
    input  logic                fetch_req_i,
    input  logic [WP_SEL_W-1:0] rgn_sel_i,
    input  logic [OFS_W-1:0]    ofs_i,
    input  logic                cfg_we_i,
    input  logic [WP_CFG_W-1:0] cfg_wdata_i,
    output logic [WP_CFG_W-1:0] cfg_rdata_o,
    output logic                wr_strb_o,
    output logic                rd_strb_o,
    output logic                fetch_strb_o,
    output logic                viol_irq_o
);

    wp_ctrl_t              ctrl;
    logic [WP_NUM_RGN-1:0] rgn_hit;
    logic                  in_window;
    logic                  guarded;
    wp_verdict_e           verdict;
    logic                  viol_set;

    wp_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we_i),
        .cfg_wdata (cfg_wdata_i),
        .viol_set  (viol_set),
        .ctrl      (ctrl)
    );

    wp_region_sel u_sel (
        .en  (ctrl.en),
        .sel (rgn_sel_i),
        .hit (rgn_hit)
    );

    wp_window_cmp #(
        .OFS_W     (OFS_W),
        .STEP_LOG2 (STEP_LOG2)
    ) u_cmp (
        .code      (ctrl.code),
        .ofs       (ofs_i),
        .in_window (in_window)
    );

    always_comb begin
        guarded = (|rgn_hit) && in_window;
    end

    wp_strobe_gate u_gate (
        .wr_req     (wr_req_i),
        .rd_req     (rd_req_i),
        .fetch_req  (fetch_req_i),
        .guarded    (guarded),
        .wr_strb    (wr_strb_o),
        .rd_strb    (rd_strb_o),
        .fetch_strb (fetch_strb_o),
        .verdict    (verdict)
    );

    always_comb begin
        viol_set    = (verdict == WP_BLOCKED);
        cfg_rdata_o = ctrl;
        viol_irq_o  = ctrl.viol;
    end

endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk
    import wp_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int STEP_LOG2 = 11
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_req_i,
    input logic                rd_req_i,
    input logic                fetch_req_i,
    input logic [WP_SEL_W-1:0] rgn_sel_i,
    input logic [OFS_W-1:0]    ofs_i,
    input logic                cfg_we_i,
    input logic [WP_CFG_W-1:0] cfg_wdata_i,
    input logic [WP_CFG_W-1:0] cfg_rdata_o,
    input logic                wr_strb_o,
    input logic                rd_strb_o,
    input logic                fetch_strb_o,
    input logic                viol_irq_o
);

    // independent limit computed from the visible register contents
    logic [31:0] chk_limit;
    logic        chk_prot;
    always_comb begin
        chk_limit = (32'(cfg_rdata_o[6:4]) + 32'd1) * (32'd1 << STEP_LOG2);
        chk_prot  = cfg_rdata_o[rgn_sel_i] && (32'(ofs_i) < chk_limit);
    end

    p_block_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && chk_prot) |-> !wr_strb_o);

    p_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && !chk_prot) |-> wr_strb_o);

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        wr_strb_o |-> wr_req_i);

    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && !wr_strb_o) |=> cfg_rdata_o[7]);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata_o[7] && !(cfg_we_i && !cfg_wdata_i[7])) |=> cfg_rdata_o[7]);

    p_no_self_set_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata_o[7] && !(wr_req_i && !wr_strb_o)) |=> !cfg_rdata_o[7]);

    p_irq_mirror_r6: assert property (@(posedge clk) disable iff (rst)
        viol_irq_o == cfg_rdata_o[7]);

    p_passthru_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_strb_o == rd_req_i) && (fetch_strb_o == fetch_req_i));

    p_cfg_load_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_we_i |=> (cfg_rdata_o[6:0] == $past(cfg_wdata_i[6:0])));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_we_i |=> $stable(cfg_rdata_o[6:0]));

endmodule

bind wrprot_gate wp_gate_chk #(
    .OFS_W     (OFS_W),
    .STEP_LOG2 (STEP_LOG2)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_req_i     (wr_req_i),
    .rd_req_i     (rd_req_i),
    .fetch_req_i  (fetch_req_i),
    .rgn_sel_i    (rgn_sel_i),
    .ofs_i        (ofs_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .wr_strb_o    (wr_strb_o),
    .rd_strb_o    (rd_strb_o),
    .fetch_strb_o (fetch_strb_o),
    .viol_irq_o   (viol_irq_o)
);

// File: tb/wrprot_gate_test.sv
module wrprot_gate_test;

    localparam int CLK_PERIOD = 10;
    localparam int OFS_W      = 16;
    localparam int STEP       = 2048;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_req_i = 1'b0;
    logic              rd_req_i = 1'b0;
    logic              fetch_req_i = 1'b0;
    logic [1:0]        rgn_sel_i = '0;
    logic [OFS_W-1:0]  ofs_i = '0;
    logic              cfg_we_i = 1'b0;
    logic [7:0]        cfg_wdata_i = '0;
    logic [7:0]        cfg_rdata_o;
    logic              wr_strb_o;
    logic              rd_strb_o;
    logic              fetch_strb_o;
    logic              viol_irq_o;

    int checks = 0;
    int failures = 0;

    // reference state
    int m_en = 0;
    int m_code = 0;
    int m_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrprot_gate #(.OFS_W(OFS_W), .STEP_LOG2(11)) uut (
        .clk          (clk),
        .rst          (rst),
        .wr_req_i     (wr_req_i),
        .rd_req_i     (rd_req_i),
        .fetch_req_i  (fetch_req_i),
        .rgn_sel_i    (rgn_sel_i),
        .ofs_i        (ofs_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .cfg_rdata_o  (cfg_rdata_o),
        .wr_strb_o    (wr_strb_o),
        .rd_strb_o    (rd_strb_o),
        .fetch_strb_o (fetch_strb_o),
        .viol_irq_o   (viol_irq_o)
    );

    function automatic int m_reg();
        return (m_flag << 7) | (m_code << 4) | m_en;
    endfunction

    function automatic bit m_protected(int sel, int ofs);
        return ((m_en >> sel) & 1) == 1 && ofs < (m_code + 1) * STEP;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive after negedge, compare mid-low phase, update model at posedge
    task automatic step(string tag, bit wr, bit rd, bit fe, int sel, int ofs,
                        bit we, int wdata);
        bit blk;
        @(negedge clk);
        wr_req_i    = wr;
        rd_req_i    = rd;
        fetch_req_i = fe;
        rgn_sel_i   = 2'(sel);
        ofs_i       = OFS_W'(ofs);
        cfg_we_i    = we;
        cfg_wdata_i = 8'(wdata);
        #(CLK_PERIOD/4);
        blk = wr && m_protected(sel, ofs);
        chk({tag, " wr_strb"}, int'(wr_strb_o), int'(wr && !blk));
        chk("R9 rd_strb", int'(rd_strb_o), int'(rd));
        chk("R9 fetch_strb", int'(fetch_strb_o), int'(fe));
        chk({tag, " cfg_rdata"}, int'(cfg_rdata_o), m_reg());
        chk("R6 irq", int'(viol_irq_o), m_flag);
        @(posedge clk);
        if (we) begin
            m_en   = wdata & 15;
            m_code = (wdata >> 4) & 7;
        end
        if (blk) m_flag = 1;
        else if (we && ((wdata >> 7) & 1) == 0) m_flag = 0;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, nothing protected
        idle("R1");
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 3, 0, 0, 0);
        idle("R1");

        // R10: program region 0, code 0
        step("R10", 0, 0, 0, 0, 0, 1, 8'h01);
        idle("R10");
        // R3/R4: boundary with code 0
        step("R4", 1, 0, 0, 0, 'h07FF, 0, 0);
        idle("R6");
        step("R3", 1, 0, 0, 0, 'h0800, 0, 0);
        // R2: other regions untouched
        step("R2", 1, 0, 0, 1, 0, 0, 0);
        step("R2", 1, 0, 0, 2, 0, 0, 0);
        step("R2", 1, 0, 0, 3, 'h10, 0, 0);

        // R7: write 1 keeps flag, write 0 clears, write 1 does not set
        step("R7", 0, 0, 0, 0, 0, 1, 8'h81);
        idle("R7");
        step("R7", 0, 0, 0, 0, 0, 1, 8'h01);
        idle("R7");
        step("R7", 0, 0, 0, 0, 0, 1, 8'h81);
        idle("R7");

        // R9: reads and fetches at protected offsets
        step("R9", 0, 1, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 1, 0, 'h10, 0, 0);
        step("R9", 0, 1, 1, 0, 'h7FF, 0, 0);
        idle("R9");

        // R3: sweep all codes, regions 1 and 3 enabled
        for (int c = 0; c < 8; c++) begin
            step("R10", 0, 0, 0, 0, 0, 1, (c << 4) | 'hA);
            for (int r = 0; r < 4; r++) begin
                step("R3", 1, 0, 0, r, (c + 1) * STEP - 1, 0, 0);
                step("R3", 1, 0, 0, r, (c + 1) * STEP, 0, 0);
            end
            step("R7", 0, 0, 0, 0, 0, 1, (c << 4) | 'hA);
        end
        idle("R3");

        // R8: blocked write collides with a software clear
        step("R10", 0, 0, 0, 0, 0, 1, 8'h7F);
        idle("R8");
        step("R8", 1, 0, 0, 2, 'h3FFF, 1, 8'h05);
        idle("R8");
        step("R8", 1, 0, 0, 2, 'h0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 8'h00);
        idle("R1");

        // random phase, offsets near limits
        for (int i = 0; i < 3000; i++) begin
            int lim;
            int ofs;
            int pick;
            lim  = (($urandom % 8) + 1) * STEP;
            pick = $urandom % 4;
            ofs  = (pick == 0) ? lim - 1 : (pick == 1) ? lim : ($urandom % 65536);
            step("R4", ($urandom % 2) == 1, ($urandom % 3) == 0, ($urandom % 3) == 0,
                 $urandom % 4, ofs, ($urandom % 10) == 0, $urandom % 256);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule